// File: doc/BRIEF.md
# Maskable Interrupt Entry Controller

This block decides when a pending external-class interrupt is taken by a simple in-order core, and it performs the architectural state update on entry. It watches two level-sensitive request lines: a system-management request and a general external request. A request counts only while the external-enable bit of the incoming machine-state word is set. When both lines are asserted together, the system-management request is chosen.

After a request is recognised, the block runs a recoverable-halt sequence. It lets exactly one more instruction complete or fault, which the pipeline reports with a completion acknowledge. It then blocks any later completion and waits for the completed-store queue to report empty. A higher-priority exception flagged during this sequence abandons it, so that exception is serviced first. The interrupt is then recognised again once the way is clear.

On entry the block performs the following updates in one cycle:
- It saves the next-instruction address.
- It saves the low half of the machine-state word as the saved status.
- It produces the new machine-state word.
- It pulses a redirect towards the handler vector.

Top module: `irq_entry_ctrl`

## Requirements
- R1: While bit 16 of `mstate_in` (external enable; bit 0 is the most significant bit) is 0, neither request line starts the halt sequence. In that case `blk_cmpl` and `redirect` stay 0.
- R2: When both request lines are recognised in the same cycle, the system-management request is taken. Its handler vector uses offset 0x1400.
- R3: If the selected request line is 0 in a halting or draining cycle, the sequence is dropped. The block returns to idle with `blk_cmpl` low, and no redirect follows.
- R4: `blk_cmpl` is 0 while the block waits for the one completion acknowledge. It is 1 from the cycle after that acknowledge until entry. `redirect` pulses for one cycle, in the cycle after `stq_empty` is seen while draining.
- R5: A higher-priority exception flagged while halting or draining returns the block to idle. A flag raised in the cycle a request would be recognised blocks recognition. The interrupt is taken later, once the flag is gone and the request is still held.
- R6: On entry, `save_pc_q` holds the `next_pc` value presented in the cycle `stq_empty` was seen.
- R7: On entry, `save_stat_q` bits 16–31 equal `mstate_in` bits 16–31, and bits 0–15 are 0 (bit 0 is the most significant bit).
- R8: The vector is a base plus an offset. The base is 0x00000000 when `mstate_in` bit 25 (vector prefix) is 0, and 0xFFF00000 when it is 1. The offset is 0x1400 for the system-management request and 0x500 for the external request.
- R9: The new machine-state word clears bits 13, 16, 17, 18, 20, 21, 22, 23, 26, 27 and 30. Bit 31 (little-endian) is loaded from bit 15 (interrupt little-endian).
- R10: All other machine-state bits keep their prior values on entry, including bits 15, 19 and 25.
- R11: A synchronous active-high reset returns the block to idle. It clears `blk_cmpl`, `redirect`, `redirect_pc`, `save_pc_q`, `save_stat_q` and `mstate_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sm_req | input | 1 | System-management request, level |
| ext_req | input | 1 | General external request, level |
| mstate_in | input | 32 | Current machine-state word, bit 0 = MSB |
| next_pc | input | ADDR_W | Address of the next instruction to complete |
| cmpl_ack | input | 1 | Next instruction completed or faulted |
| stq_empty | input | 1 | Completed-store queue is empty |
| hp_exc | input | 1 | Higher-priority exception pending |
| blk_cmpl | output | 1 | Block further instruction completion |
| redirect | output | 1 | One-cycle fetch redirect pulse on entry |
| redirect_pc | output | ADDR_W | Handler vector |
| save_pc_q | output | ADDR_W | Saved next-instruction address |
| save_stat_q | output | 32 | Saved status word |
| mstate_out | output | 32 | New machine-state word |

## Verification
A recognised request becomes visible one cycle later, as the halting state with `blk_cmpl` still 0. `blk_cmpl` rises one cycle after the acknowledge is sampled. `redirect` and all entry registers change one cycle after `stq_empty` is sampled while draining. A dropped line or a higher-priority flag shows up as `blk_cmpl` falling one cycle after it is sampled. The bench drives inputs on the falling edge and reads outputs on the next falling edge, so every check sits exactly one register stage after the stimulus it judges. Random entries compare the saved and new words against bench functions built from R7–R10.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

   localparam int MW = 32;

   // machine-state bit indices (big-endian numbering mapped to vector index)
   localparam int B_PWR    = MW - 1 - 13;
   localparam int B_ILEND  = MW - 1 - 15;
   localparam int B_EXTEN  = MW - 1 - 16;
   localparam int B_USER   = MW - 1 - 17;
   localparam int B_FPUEN  = MW - 1 - 18;
   localparam int B_MCHK   = MW - 1 - 19;
   localparam int B_FPX0   = MW - 1 - 20;
   localparam int B_STEP   = MW - 1 - 21;
   localparam int B_BTRACE = MW - 1 - 22;
   localparam int B_FPX1   = MW - 1 - 23;
   localparam int B_VPFX   = MW - 1 - 25;
   localparam int B_IXLATE = MW - 1 - 26;
   localparam int B_DXLATE = MW - 1 - 27;
   localparam int B_RECOV  = MW - 1 - 30;
   localparam int B_LEND   = MW - 1 - 31;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_HALT  = 2'd1,
      ST_DRAIN = 2'd2,
      ST_ENTER = 2'd3
   } halt_st_t;

endpackage

// File: rtl/irq_req_arb.sv
module irq_req_arb (
   input  logic ext_en,
   input  logic sm_req,
   input  logic ext_req,
   input  logic hp_exc,
   output logic recog,
   output logic pick_sm
);
   // fixed priority: system-management first
   assign recog   = ext_en & (sm_req | ext_req) & ~hp_exc;
   assign pick_sm = sm_req;
endmodule

// File: rtl/irq_halt_fsm.sv
module irq_halt_fsm
   import irq_entry_pkg::*;
#(
   parameter bit DROP_ON_NEGATE = 1'b1
) (
   input  logic     clk,
   input  logic     rst,
   input  logic     recog,
   input  logic     pick_sm,
   input  logic     sm_req,
   input  logic     ext_req,
   input  logic     cmpl_ack,
   input  logic     stq_empty,
   input  logic     hp_exc,
   output halt_st_t state,
   output logic     sel_sm,
   output logic     load_en
);
   halt_st_t state_q, state_d;
   logic     sel_sm_q;
   logic     line_gone;

   generate
      if (DROP_ON_NEGATE) begin : g_drop
         assign line_gone = sel_sm_q ? ~sm_req : ~ext_req;
      end else begin : g_keep
         assign line_gone = 1'b0;
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (recog) state_d = ST_HALT;
         ST_HALT: begin
            if (hp_exc || line_gone) state_d = ST_IDLE;
            else if (cmpl_ack)       state_d = ST_DRAIN;
         end
         ST_DRAIN: begin
            if (hp_exc || line_gone) state_d = ST_IDLE;
            else if (stq_empty)      state_d = ST_ENTER;
         end
         ST_ENTER: state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q  <= ST_IDLE;
         sel_sm_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && recog) sel_sm_q <= pick_sm;
      end
   end

   assign state   = state_q;
   assign sel_sm  = sel_sm_q;
   assign load_en = (state_q == ST_DRAIN) && stq_empty && !hp_exc && !line_gone;
endmodule

// File: rtl/irq_state_xform.sv
module irq_state_xform
   import irq_entry_pkg::*;
#(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned SM_OFF  = 32'h1400,
   parameter int unsigned EXT_OFF = 32'h0500
) (
   input  logic [MW-1:0]     mstate_in,
   input  logic              sel_sm,
   output logic [MW-1:0]     new_mstate,
   output logic [MW-1:0]     new_stat,
   output logic [ADDR_W-1:0] vector
);
   localparam logic [ADDR_W-1:0] BASE_HI = {{(ADDR_W-20){1'b1}}, 20'h0};
   localparam logic [ADDR_W-1:0] OFF_SM  = ADDR_W'(SM_OFF);
   localparam logic [ADDR_W-1:0] OFF_EXT = ADDR_W'(EXT_OFF);

   localparam logic [MW-1:0] CLR_MASK =
      (MW'(1) << B_PWR)   | (MW'(1) << B_EXTEN)  | (MW'(1) << B_USER)   |
      (MW'(1) << B_FPUEN) | (MW'(1) << B_FPX0)   | (MW'(1) << B_FPX1)   |
      (MW'(1) << B_STEP)  | (MW'(1) << B_BTRACE) | (MW'(1) << B_IXLATE) |
      (MW'(1) << B_DXLATE)| (MW'(1) << B_RECOV)  | (MW'(1) << B_LEND);

   logic [ADDR_W-1:0] base;

   always_comb begin
      new_mstate         = mstate_in & ~CLR_MASK;
      new_mstate[B_LEND] = mstate_in[B_ILEND];
   end

   assign new_stat = {{(MW/2){1'b0}}, mstate_in[MW/2-1:0]};
   assign base     = mstate_in[B_VPFX] ? BASE_HI : '0;
   assign vector   = base | (sel_sm ? OFF_SM : OFF_EXT);
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
   import irq_entry_pkg::*;
#(
   parameter int unsigned ADDR_W         = 32,
   parameter int unsigned SM_OFF         = 32'h1400,
   parameter int unsigned EXT_OFF        = 32'h0500,
   parameter bit          DROP_ON_NEGATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sm_req,
   input  logic              ext_req,
   input  logic [31:0]       mstate_in,
   input  logic [ADDR_W-1:0] next_pc,
   input  logic              cmpl_ack,
   input  logic              stq_empty,
   input  logic              hp_exc,
   output logic              blk_cmpl,
   output logic              redirect,
   output logic [ADDR_W-1:0] redirect_pc,
   output logic [ADDR_W-1:0] save_pc_q,
   output logic [31:0]       save_stat_q,
   output logic [31:0]       mstate_out
);
   generate
      if (ADDR_W < 21) begin : g_bad_aw
         $error("ADDR_W must be at least 21");
      end
      if (SM_OFF >= 32'h100000 || EXT_OFF >= 32'h100000) begin : g_bad_off
         $error("vector offsets must fit below the base");
      end
      if (SM_OFF == EXT_OFF) begin : g_same_off
         $error("vector offsets must differ");
      end
   endgenerate

   logic              recog, pick_sm, sel_sm, load_en;
   halt_st_t          st;
   logic [MW-1:0]     new_mstate, new_stat;
   logic [ADDR_W-1:0] vector;

   irq_req_arb u_arb (
      .ext_en  (mstate_in[B_EXTEN]),
      .sm_req  (sm_req),
      .ext_req (ext_req),
      .hp_exc  (hp_exc),
      .recog   (recog),
      .pick_sm (pick_sm)
   );

   irq_halt_fsm #(.DROP_ON_NEGATE(DROP_ON_NEGATE)) u_fsm (
      .clk       (clk),
      .rst       (rst),
      .recog     (recog),
      .pick_sm   (pick_sm),
      .sm_req    (sm_req),
      .ext_req   (ext_req),
      .cmpl_ack  (cmpl_ack),
      .stq_empty (stq_empty),
      .hp_exc    (hp_exc),
      .state     (st),
      .sel_sm    (sel_sm),
      .load_en   (load_en)
   );

   irq_state_xform #(.ADDR_W(ADDR_W), .SM_OFF(SM_OFF), .EXT_OFF(EXT_OFF)) u_xf (
      .mstate_in  (mstate_in),
      .sel_sm     (sel_sm),
      .new_mstate (new_mstate),
      .new_stat   (new_stat),
      .vector     (vector)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         save_pc_q   <= '0;
         save_stat_q <= '0;
         mstate_out  <= '0;
         redirect_pc <= '0;
      end else if (load_en) begin
         save_pc_q   <= next_pc;
         save_stat_q <= new_stat;
         mstate_out  <= new_mstate;
         redirect_pc <= vector;
      end
   end

   assign redirect = (st == ST_ENTER);
   assign blk_cmpl = (st == ST_DRAIN) || (st == ST_ENTER);
endmodule

// File: rtl/irq_entry_ctrl_chk.sv
module irq_entry_ctrl_chk
   import irq_entry_pkg::*;
#(
   parameter int unsigned ADDR_W         = 32,
   parameter bit          DROP_ON_NEGATE = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic [31:0]       mstate_in,
   input logic              sm_req,
   input logic              ext_req,
   input logic              hp_exc,
   input logic              stq_empty,
   input logic              blk_cmpl,
   input logic              redirect,
   input logic [ADDR_W-1:0] redirect_pc,
   input logic [31:0]       save_stat_q,
   input logic [31:0]       mstate_out,
   input halt_st_t          st,
   input logic              sel_sm
);
   a_r1_gate_off: assert property (@(posedge clk) disable iff (rst)
      (st == ST_IDLE && !mstate_in[B_EXTEN]) |=> (st == ST_IDLE));

   a_r2_sm_first: assert property (@(posedge clk) disable iff (rst)
      (st == ST_IDLE && mstate_in[B_EXTEN] && sm_req && ext_req && !hp_exc)
      |=> (st == ST_HALT && sel_sm));

   generate
      if (DROP_ON_NEGATE) begin : g_drop_chk
         a_r3_line_drop: assert property (@(posedge clk) disable iff (rst)
            (st == ST_HALT && sel_sm && !sm_req) |=> (st == ST_IDLE));
      end
   endgenerate

   a_r4_entry_after_drain: assert property (@(posedge clk) disable iff (rst)
      redirect |-> (blk_cmpl && $past(stq_empty)));

   a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
      redirect |=> !redirect);

   a_r5_preempt: assert property (@(posedge clk) disable iff (rst)
      ((st == ST_HALT || st == ST_DRAIN) && hp_exc) |=> (st == ST_IDLE));

   a_r7_stat_upper_zero: assert property (@(posedge clk) disable iff (rst)
      redirect |-> (save_stat_q[31:16] == 16'h0));

   a_r8_vec_align: assert property (@(posedge clk) disable iff (rst)
      redirect |-> (redirect_pc[7:0] == 8'h0));

   a_r9_new_word: assert property (@(posedge clk) disable iff (rst)
      redirect |-> (!mstate_out[B_EXTEN] && mstate_out[B_LEND] == mstate_out[B_ILEND]));
endmodule

bind irq_entry_ctrl irq_entry_ctrl_chk #(.ADDR_W(ADDR_W), .DROP_ON_NEGATE(DROP_ON_NEGATE)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .mstate_in   (mstate_in),
   .sm_req      (sm_req),
   .ext_req     (ext_req),
   .hp_exc      (hp_exc),
   .stq_empty   (stq_empty),
   .blk_cmpl    (blk_cmpl),
   .redirect    (redirect),
   .redirect_pc (redirect_pc),
   .save_stat_q (save_stat_q),
   .mstate_out  (mstate_out),
   .st          (st),
   .sel_sm      (sel_sm)
);

// File: tb/irq_entry_ctrl_test.sv
module irq_entry_ctrl_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        sm_req = 0, ext_req = 0, cmpl_ack = 0, stq_empty = 0, hp_exc = 0;
   logic [31:0] mstate_in = 0, next_pc = 0;
   logic        blk_cmpl, redirect;
   logic [31:0] redirect_pc, save_pc_q, save_stat_q, mstate_out;
   int          n_chk = 0, n_fail = 0;

   always #5 clk = ~clk;

   irq_entry_ctrl uut (
      .clk(clk), .rst(rst), .sm_req(sm_req), .ext_req(ext_req),
      .mstate_in(mstate_in), .next_pc(next_pc), .cmpl_ack(cmpl_ack),
      .stq_empty(stq_empty), .hp_exc(hp_exc), .blk_cmpl(blk_cmpl),
      .redirect(redirect), .redirect_pc(redirect_pc), .save_pc_q(save_pc_q),
      .save_stat_q(save_stat_q), .mstate_out(mstate_out)
   );

   function automatic int bi(input int n); return 31 - n; endfunction

   function automatic logic [31:0] exp_stat(input logic [31:0] m);
      return {16'h0, m[15:0]};
   endfunction

   function automatic logic [31:0] exp_word(input logic [31:0] m);
      logic [31:0] r = m;
      int clr[11] = '{13, 16, 17, 18, 20, 21, 22, 23, 26, 27, 30};
      foreach (clr[i]) r[bi(clr[i])] = 1'b0;
      r[bi(31)] = m[bi(15)];
      return r;
   endfunction

   function automatic logic [31:0] exp_vec(input logic [31:0] m, input logic sm);
      return (m[bi(25)] ? 32'hFFF0_0000 : 32'h0) | (sm ? 32'h1400 : 32'h0500);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_entry(input logic sm, input logic ext, input logic [31:0] m,
                            input logic [31:0] pc, input int waits);
      @(negedge clk);
      sm_req = sm; ext_req = ext; mstate_in = m; hp_exc = 0; cmpl_ack = 0; stq_empty = 0;
      @(negedge clk);
      chk("R4 no block while halting", 32'(blk_cmpl), 32'd0);
      cmpl_ack = 1;
      @(negedge clk);
      cmpl_ack = 0;
      chk("R4 block after ack", 32'(blk_cmpl), 32'd1);
      chk("R4 no early redirect", 32'(redirect), 32'd0);
      for (int i = 0; i < waits; i++) begin
         @(negedge clk);
         chk("R4 wait for drain", 32'(redirect), 32'd0);
      end
      stq_empty = 1; next_pc = pc;
      @(negedge clk);
      stq_empty = 0; sm_req = 0; ext_req = 0;
      chk("R4 redirect pulse", 32'(redirect), 32'd1);
      chk("R6 saved pc", save_pc_q, pc);
      chk("R7 saved status", save_stat_q, exp_stat(m));
      chk("R8 vector", redirect_pc, exp_vec(m, sm));
      chk("R9 R10 new word", mstate_out, exp_word(m));
      @(negedge clk);
      chk("R4 pulse ends", 32'(redirect), 32'd0);
      chk("R4 block released", 32'(blk_cmpl), 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 0;
      // R11 reset state
      chk("R11 blk", 32'(blk_cmpl), 0);
      chk("R11 redirect", 32'(redirect), 0);
      chk("R11 vector", redirect_pc, 0);
      chk("R11 saved pc", save_pc_q, 0);
      chk("R11 saved status", save_stat_q, 0);
      chk("R11 word", mstate_out, 0);

      // R1: enable off, requests ignored
      sm_req = 1; ext_req = 1; mstate_in = 32'hFFFF_FFFF; mstate_in[15] = 0;
      cmpl_ack = 1; stq_empty = 1;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk("R1 blk stays low", 32'(blk_cmpl), 0);
         chk("R1 no redirect", 32'(redirect), 0);
      end
      chk("R1 saved pc untouched", save_pc_q, 0);
      sm_req = 0; ext_req = 0; cmpl_ack = 0; stq_empty = 0;

      // R2 both lines, R8 base 0
      run_entry(1, 1, 32'h0001_8000, 32'h0000_4444, 1);
      // external only, R8 prefix set
      run_entry(0, 1, 32'h0001_8042, 32'h1234_5678, 0);
      // R10 keep bits: ILE, ME, IP set
      run_entry(1, 0, 32'h8001_9043, 32'hDEAD_BEE0, 2);
      chk("R10 keep ILE", 32'(mstate_out[16]), 1);
      chk("R10 keep ME", 32'(mstate_out[12]), 1);
      chk("R10 keep prefix", 32'(mstate_out[6]), 1);

      // R3 drop in halting
      @(negedge clk);
      sm_req = 1; mstate_in = 32'h0000_8000;
      @(negedge clk);
      sm_req = 0;
      @(negedge clk);
      chk("R3 drop while halting", 32'(blk_cmpl), 0);
      cmpl_ack = 1; stq_empty = 1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R3 no redirect after drop", 32'(redirect), 0);
      end
      cmpl_ack = 0; stq_empty = 0;

      // R3 drop in draining
      ext_req = 1;
      @(negedge clk);
      cmpl_ack = 1;
      @(negedge clk);
      cmpl_ack = 0;
      chk("R3 draining blk", 32'(blk_cmpl), 1);
      ext_req = 0;
      @(negedge clk);
      chk("R3 drop while draining", 32'(blk_cmpl), 0);
      chk("R3 no redirect", 32'(redirect), 0);

      // R5 flag at recognition blocks it
      sm_req = 1; hp_exc = 1; cmpl_ack = 1; stq_empty = 1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R5 blocked recognition", 32'(blk_cmpl | redirect), 0);
      end
      sm_req = 0; hp_exc = 0; cmpl_ack = 0; stq_empty = 0;
      @(negedge clk);

      // R5 pre-empt while draining, then deferred entry
      ext_req = 1; mstate_in = 32'h0000_8000;
      @(negedge clk);
      cmpl_ack = 1;
      @(negedge clk);
      cmpl_ack = 0; hp_exc = 1;
      @(negedge clk);
      hp_exc = 0;
      chk("R5 pre-empted", 32'(blk_cmpl), 0);
      @(negedge clk);
      chk("R5 re-halting", 32'(blk_cmpl), 0);
      cmpl_ack = 1;
      @(negedge clk);
      cmpl_ack = 0; stq_empty = 1; next_pc = 32'h0000_0900;
      @(negedge clk);
      stq_empty = 0; ext_req = 0;
      chk("R5 deferred entry", 32'(redirect), 1);
      chk("R5 deferred vector", redirect_pc, 32'h0000_0500);
      @(negedge clk);

      // random entries
      for (int k = 0; k < 40; k++) begin
         logic [31:0] m = $urandom;
         logic s = 1'($urandom);
         logic e = 1'($urandom);
         m[15] = 1'b1;
         if (!s && !e) e = 1'b1;
         run_entry(s, e, m, $urandom, int'($urandom % 4));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule